// File: doc/BRIEF.md
# Byte-Parity Memory Slave with Error Register and Trap Flag

This block is a small word-organised memory with a simple request/acknowledge bus slave in front of it. Each byte of every stored word has its own odd-parity bit. The parity bit is computed on every write and checked on every read. A control/status register at a fixed bus address holds two bits. One bit enables the reporting of parity errors on the bus. The other is a sticky flag that records that an error was seen, and it drives an indicator output.

On the processor side, a small capture stage latches the bus parity-error line into an error flip-flop. That flip-flop raises a trap request unless a strap input masks it, and an acknowledge from the processor clears it. A diagnostic input can store inverted parity on the lanes being written, so that error paths can be exercised on purpose.

A cycle is started by holding `bus_req` high for one clock cycle. If the address hits the memory window or the register, `bus_ack` is high in the following cycle. On a read, `bus_rdata` and `bus_perr` are valid in that same cycle.

Top module: `parity_mem_unit`

## Requirements
- R1: After reset `bus_ack`, `bus_perr`, `err_led` and `trap_req` are low, and the register reads as 0x0000.
- R2: A request to a mapped address is acknowledged exactly one cycle later. A word written and then read back returns the written data.
- R3: A byte write (`bus_byte`=1) changes only the addressed byte. An even address takes `bus_wdata[7:0]` into the low byte, and an odd address takes `bus_wdata[15:8]` into the high byte. The other byte and its parity are left intact. A read always returns the whole word.
- R4: Each byte is stored with odd parity. If `bad_par[i]` is 1 during a write, lane i (0 = low byte, 1 = high byte) stores inverted parity, and a later read of that word detects an error. Rewriting the word with `bad_par` at 0 removes the error.
- R5: `bus_perr` rises together with `bus_ack` on a read that detects an error, and only when register bit 0 is 1. It is never asserted for a write cycle.
- R6: Any read that detects an error sets register bit 15, whatever the value of bit 0. `err_led` follows bit 15 and rises in the same cycle as the read's acknowledge.
- R7: The register sits at octal byte address 772100 (word and byte access; 772101 is the high byte). Bit 0 is read/write. Bit 15 is cleared by writing 0 to it, and writing 1 to it has no effect. All other bits read as 0. Register accesses never assert `bus_perr`.
- R8: The error flip-flop sets in the cycle after `bus_perr` is high. `trap_req` is the flip-flop value gated by `trap_mask` low, and the mask does not clear the flip-flop.
- R9: A one-cycle `trap_ack` clears the error flip-flop, so `trap_req` is low in the next cycle.
- R10: Addresses outside the memory window (byte address 2*WORDS and up) and outside the register are not acknowledged, and they change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | One-cycle cycle request |
| bus_we | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_byte | input | 1 | 1 = byte write, 0 = word |
| bus_addr | input | 18 | Byte address |
| bus_wdata | input | 16 | Write data (byte lanes by address bit 0) |
| bad_par | input | 2 | Per-lane diagnostic: store inverted parity |
| trap_mask | input | 1 | Strap that suppresses the trap request |
| trap_ack | input | 1 | Processor acknowledge; clears the error flip-flop |
| bus_ack | output | 1 | Cycle acknowledge, one cycle after the request |
| bus_rdata | output | 16 | Read data, valid with the acknowledge |
| bus_perr | output | 1 | Bus parity-error line |
| err_led | output | 1 | Error indicator (register bit 15) |
| trap_req | output | 1 | Trap request to the processor |

## Verification
A stored parity bit that is corrupted, or a wrong lane enable on a byte write, shows up at the ports on the next read of that word. It appears either as wrong data or as `err_led` rising with that read's acknowledge, one cycle after the request. A wrong enable or flag state in the register is visible on the next register read, and also through `bus_perr` on the next failing read. A fault in the error flip-flop appears on `trap_req` one cycle after `bus_perr`, or one cycle after `trap_ack`. Corruption is injected with `bad_par`, and the bench confirms that it is reported on reads only when bit 0 is set and is never reported on writes.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_MEM  = 2'd1,
    ACC_REG  = 2'd2
  } acc_t;

  // Parity bit that makes the 9-bit group carry an odd number of ones
  function automatic logic odd_bit(input logic [7:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/pmem_decode.sv
module pmem_decode #(
  parameter int                ADDR_W   = 18,
  parameter int                WORDS    = 256,
  parameter logic [ADDR_W-1:0] REG_ADDR = 18'o772100
) (
  input  logic [ADDR_W-1:0]          addr,
  output pmem_pkg::acc_t             sel,
  output logic [$clog2(WORDS)-1:0]   idx,
  output logic                       hi_byte
);
  localparam int IDX_W = $clog2(WORDS);

  logic in_mem;
  logic in_reg;

  always_comb begin
    in_mem  = (addr[ADDR_W-1:IDX_W+1] == '0);
    in_reg  = (addr[ADDR_W-1:1] == REG_ADDR[ADDR_W-1:1]);
    idx     = addr[IDX_W:1];
    hi_byte = addr[0];
    if (in_mem)      sel = pmem_pkg::ACC_MEM;
    else if (in_reg) sel = pmem_pkg::ACC_REG;
    else             sel = pmem_pkg::ACC_NONE;
  end

endmodule

// File: rtl/pmem_array.sv
module pmem_array #(
  parameter int WORDS = 256
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [$clog2(WORDS)-1:0]     idx,
  input  logic [pmem_pkg::LANES-1:0]   lane_we,
  input  logic [pmem_pkg::DATA_W-1:0]  wdata,
  input  logic [pmem_pkg::LANES-1:0]   bad_par,
  output logic [pmem_pkg::DATA_W-1:0]  rdata,
  output logic                         par_err
);
  localparam int LANES = pmem_pkg::LANES;

  logic [LANES-1:0] lane_err;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [8:0] bank [WORDS];
    logic [8:0] rd_word;
    logic [7:0] wr_byte;
    logic       wr_par;

    always_comb begin
      wr_byte = wdata[8*g +: 8];
      wr_par  = pmem_pkg::odd_bit(wr_byte) ^ bad_par[g];
      rd_word = bank[idx];
    end

    always_ff @(posedge clk) begin
      if (wr_en && lane_we[g]) begin
        bank[idx] <= {wr_par, wr_byte};
      end
    end

    assign rdata[8*g +: 8] = rd_word[7:0];
    assign lane_err[g]     = ~(^rd_word);
  end

  assign par_err = |lane_err;

endmodule

// File: rtl/pmem_csr.sv
module pmem_csr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [15:0] wdata,
  input  logic        set_err,
  output logic        report_en,
  output logic        err_flag
);
  logic en_d;
  logic flag_d;

  always_comb begin
    en_d   = report_en;
    flag_d = err_flag;
    if (wr_lo) en_d = wdata[0];
    if (wr_hi && !wdata[15]) flag_d = 1'b0;
    if (set_err) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      report_en <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      report_en <= en_d;
      err_flag  <= flag_d;
    end
  end

endmodule

// File: rtl/pmem_trap.sv
module pmem_trap (
  input  logic clk,
  input  logic rst_n,
  input  logic perr_line,
  input  logic ack,
  input  logic mask,
  output logic trap_req
);
  logic hold_q;
  logic hold_d;

  always_comb begin
    hold_d = hold_q;
    if (ack)       hold_d = 1'b0;
    if (perr_line) hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign trap_req = hold_q & ~mask;

endmodule

// File: rtl/parity_mem_unit.sv
module parity_mem_unit #(
  parameter int                ADDR_W   = 18,
  parameter int                WORDS    = 256,
  parameter logic [ADDR_W-1:0] REG_ADDR = 18'o772100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic [1:0]        bad_par,
  input  logic              trap_mask,
  input  logic              trap_ack,
  output logic              bus_ack,
  output logic [15:0]       bus_rdata,
  output logic              bus_perr,
  output logic              err_led,
  output logic              trap_req
);
  import pmem_pkg::*;

  localparam int IDX_W = $clog2(WORDS);

  acc_t             sel;
  logic [IDX_W-1:0] idx;
  logic             hi_byte;
  logic [LANES-1:0] lane_we;
  logic [15:0]      arr_rdata;
  logic             arr_err;
  logic             mem_wr, mem_rd, reg_rd, reg_wr_lo, reg_wr_hi;
  logic             set_err;
  logic             csr_en, csr_flag;
  logic             ack_d, perr_d;
  logic [15:0]      rdata_d;
  logic             ack_q, perr_q;
  logic [15:0]      rdata_q;

  pmem_decode #(.ADDR_W(ADDR_W), .WORDS(WORDS), .REG_ADDR(REG_ADDR)) u_decode (
    .addr    (bus_addr),
    .sel     (sel),
    .idx     (idx),
    .hi_byte (hi_byte)
  );

  always_comb begin
    lane_we   = bus_byte ? (hi_byte ? 2'b10 : 2'b01) : 2'b11;
    mem_wr    = bus_req &  bus_we & (sel == ACC_MEM);
    mem_rd    = bus_req & ~bus_we & (sel == ACC_MEM);
    reg_rd    = bus_req & ~bus_we & (sel == ACC_REG);
    reg_wr_lo = bus_req &  bus_we & (sel == ACC_REG) & (~bus_byte | ~hi_byte);
    reg_wr_hi = bus_req &  bus_we & (sel == ACC_REG) & (~bus_byte |  hi_byte);
    set_err   = mem_rd & arr_err;
  end

  pmem_array #(.WORDS(WORDS)) u_array (
    .clk     (clk),
    .wr_en   (mem_wr),
    .idx     (idx),
    .lane_we (lane_we),
    .wdata   (bus_wdata),
    .bad_par (bad_par),
    .rdata   (arr_rdata),
    .par_err (arr_err)
  );

  pmem_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lo     (reg_wr_lo),
    .wr_hi     (reg_wr_hi),
    .wdata     (bus_wdata),
    .set_err   (set_err),
    .report_en (csr_en),
    .err_flag  (csr_flag)
  );

  // Response next state
  always_comb begin
    ack_d   = bus_req & (sel != ACC_NONE);
    perr_d  = set_err & csr_en;
    rdata_d = 16'h0000;
    if (mem_rd)      rdata_d = arr_rdata;
    else if (reg_rd) rdata_d = {csr_flag, 14'b0, csr_en};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      perr_q  <= 1'b0;
      rdata_q <= 16'h0000;
    end else begin
      ack_q   <= ack_d;
      perr_q  <= perr_d;
      rdata_q <= rdata_d;
    end
  end

  pmem_trap u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .perr_line (perr_q),
    .ack       (trap_ack),
    .mask      (trap_mask),
    .trap_req  (trap_req)
  );

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign bus_perr  = perr_q;
  assign err_led   = csr_flag;

endmodule

// File: rtl/pmem_checker.sv
module pmem_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_req,
  input logic bus_we,
  input logic bus_ack,
  input logic bus_perr,
  input logic err_led,
  input logic csr_en,
  input logic trap_mask,
  input logic trap_ack,
  input logic trap_req
);

  // R2: an acknowledge only ever follows a request
  assert_ack_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_req));

  // R5: a write cycle never reports a parity error
  assert_no_perr_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_req && bus_we) |-> !bus_perr);

  // R5: error line only with acknowledge and reporting enabled
  assert_perr_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_perr |-> (bus_ack && csr_en));

  // R6: indicator is lit whenever the line reports
  assert_led_with_perr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_perr |-> err_led);

  // R8: captured error raises a trap unless masked
  assert_trap_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_perr |=> (trap_req || trap_mask));

  // R9: acknowledge clears the flip-flop
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ack && !bus_perr) |=> !trap_req);

endmodule

bind parity_mem_unit pmem_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_ack   (bus_ack),
  .bus_perr  (bus_perr),
  .err_led   (err_led),
  .csr_en    (csr_en),
  .trap_mask (trap_mask),
  .trap_ack  (trap_ack),
  .trap_req  (trap_req)
);

// File: tb/parity_mem_unit_bench.sv
`timescale 1ns/1ps
module parity_mem_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we, bus_byte;
  logic [17:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [1:0]  bad_par;
  logic        trap_mask, trap_ack;
  logic        bus_ack, bus_perr, err_led, trap_req;
  logic [15:0] bus_rdata;

  localparam logic [17:0] REG_A = 18'o772100;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int          due;
    bit          ack;
    logic [15:0] data;
    bit          cdata;
    bit          perr;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  parity_mem_unit u_parity_mem_unit (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bad_par(bad_par), .trap_mask(trap_mask), .trap_ack(trap_ack),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_perr(bus_perr),
    .err_led(err_led), .trap_req(trap_req)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_cycle(input bit we, input bit bt, input logic [17:0] a,
                           input logic [15:0] wd, input logic [1:0] bp,
                           input bit e_ack, input logic [15:0] e_d, input bit cd,
                           input bit e_p, input string tag);
    exp_t it;
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_byte = bt; bus_addr = a;
    bus_wdata = wd; bad_par = bp;
    it.due = cyc + 1; it.ack = e_ack; it.data = e_d; it.cdata = cd;
    it.perr = e_p; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_req = 1'b0; bad_par = 2'b00;
  endtask

  task automatic wr(input logic [17:0] a, input logic [15:0] wd, input logic [1:0] bp, input string tag);
    bus_cycle(1'b1, 1'b0, a, wd, bp, 1'b1, 16'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic rd(input logic [17:0] a, input logic [15:0] ed, input bit ep, input string tag);
    bus_cycle(1'b0, 1'b0, a, 16'h0, 2'b00, 1'b1, ed, 1'b1, ep, tag);
  endtask

  // Monitor: pops expected responses and compares
  initial begin
    exp_t it;
    forever begin
      @(negedge clk); #1;
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        it = exp_q.pop_front();
        chk(bus_ack == it.ack, {it.tag, " ack"}, {15'b0, bus_ack}, {15'b0, it.ack});
        if (it.ack) begin
          chk(bus_perr == it.perr, {it.tag, " perr"}, {15'b0, bus_perr}, {15'b0, it.perr});
          if (it.cdata) chk(bus_rdata == it.data, {it.tag, " data"}, bus_rdata, it.data);
        end
      end else if (bus_ack === 1'b1) begin
        chk(1'b0, "R2 unexpected ack", 16'h1, 16'h0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_byte = 1'b0;
    bus_addr = '0; bus_wdata = '0; bad_par = 2'b00;
    trap_mask = 1'b0; trap_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(bus_ack == 0,  "R1 ack idle", {15'b0, bus_ack}, 16'h0);
    chk(bus_perr == 0, "R1 perr idle", {15'b0, bus_perr}, 16'h0);
    chk(err_led == 0,  "R1 led idle", {15'b0, err_led}, 16'h0);
    chk(trap_req == 0, "R1 trap idle", {15'b0, trap_req}, 16'h0);
    rd(REG_A, 16'h0000, 0, "R1 reg reset value");

    // R2 word round trip
    wr(18'd0, 16'h1234, 2'b00, "R2 write w0");
    rd(18'd0, 16'h1234, 0, "R2 read w0");
    wr(18'd20, 16'hA5F0, 2'b00, "R2 write w10");
    rd(18'd20, 16'hA5F0, 0, "R2 read w10");

    // R3 byte lanes
    bus_cycle(1, 1, 18'd21, 16'h3C00, 2'b00, 1, 16'h0, 0, 0, "R3 byte write high");
    rd(18'd20, 16'h3CF0, 0, "R3 high byte only");
    bus_cycle(1, 1, 18'd20, 16'h0077, 2'b00, 1, 16'h0, 0, 0, "R3 byte write low");
    rd(18'd21, 16'h3C77, 0, "R3 low byte only");
    #2 chk(err_led == 0, "R3 parity kept on byte write", {15'b0, err_led}, 16'h0);

    // R4/R6 corrupted low lane, reporting disabled
    wr(18'd40, 16'h00FF, 2'b01, "R5 write with bad parity no perr");
    rd(18'd40, 16'h00FF, 0, "R5 disabled read no perr");
    #2 chk(err_led == 1, "R6 led on error while disabled", {15'b0, err_led}, 16'h1);
    @(negedge clk); #2;
    chk(trap_req == 0, "R8 no trap without perr", {15'b0, trap_req}, 16'h0);
    rd(REG_A, 16'h8000, 0, "R6 flag bit 15 set");

    // R7 clear flag, enable reporting
    wr(REG_A, 16'h0001, 2'b00, "R7 clear flag set enable");
    rd(REG_A, 16'h0001, 0, "R7 reg after write");
    #2 chk(err_led == 0, "R7 led cleared", {15'b0, err_led}, 16'h0);

    // R5 enabled: write silent, read reports
    wr(18'd42, 16'h1357, 2'b10, "R5 enabled write never perr");
    #2 chk(err_led == 0, "R5 write sets no flag", {15'b0, err_led}, 16'h0);
    rd(18'd42, 16'h1357, 1, "R4 R5 enabled read reports");
    #2 chk(err_led == 1, "R6 led with perr", {15'b0, err_led}, 16'h1);
    @(negedge clk); #2;
    chk(trap_req == 1, "R8 trap after perr", {15'b0, trap_req}, 16'h1);

    // R9 acknowledge clears
    @(negedge clk); trap_ack = 1'b1;
    @(negedge clk); trap_ack = 1'b0; #2;
    chk(trap_req == 0, "R9 ack clears trap", {15'b0, trap_req}, 16'h0);

    // R8 mask hides without clearing
    trap_mask = 1'b1;
    rd(18'd42, 16'h1357, 1, "R5 masked read still reports");
    @(negedge clk); #2;
    chk(trap_req == 0, "R8 mask suppresses trap", {15'b0, trap_req}, 16'h0);
    trap_mask = 1'b0; #1;
    chk(trap_req == 1, "R8 mask keeps flip-flop", {15'b0, trap_req}, 16'h1);
    @(negedge clk); trap_ack = 1'b1;
    @(negedge clk); trap_ack = 1'b0; #2;
    chk(trap_req == 0, "R9 second clear", {15'b0, trap_req}, 16'h0);

    // R7 field behaviour
    wr(REG_A, 16'h8001, 2'b00, "R7 write one to flag");
    rd(REG_A, 16'h8001, 0, "R7 writing one keeps flag");
    bus_cycle(1, 1, REG_A + 18'd1, 16'h0000, 2'b00, 1, 16'h0, 0, 0, "R7 high byte write");
    rd(REG_A, 16'h0001, 0, "R7 byte clear keeps enable");
    wr(REG_A, 16'hFFFE, 2'b00, "R7 write other bits");
    rd(REG_A, 16'h0000, 0, "R7 other bits read zero");

    // R4 heal by rewrite
    wr(18'd42, 16'h2468, 2'b00, "R4 rewrite good parity");
    rd(18'd42, 16'h2468, 0, "R4 rewritten word clean");
    #2 chk(err_led == 0, "R4 no error after rewrite", {15'b0, err_led}, 16'h0);

    // R10 unmapped addresses
    bus_cycle(0, 0, 18'o001000, 16'h0, 2'b00, 0, 16'h0, 0, 0, "R10 read past window");
    bus_cycle(1, 0, 18'o001000, 16'hFFFF, 2'b00, 0, 16'h0, 0, 0, "R10 write past window");
    bus_cycle(0, 0, 18'o772104, 16'h0, 2'b00, 0, 16'h0, 0, 0, "R10 read near register");
    rd(18'd0, 16'h1234, 0, "R10 no aliasing");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all responses seen", 16'(exp_q.size()), 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule